// File: doc/BRIEF.md
# Transfer Address and Count Updater

This block works out the register values a disk controller holds after a data transfer. It takes the values at the start: a negated word count, a 16-bit bus address with a 2-bit memory extension, and a disk address made of drive, track and sector fields. It also takes the number of words the transfer attempted and the number that a memory fault left unmoved. From these it produces the final word count, the final 18-bit bus address split back into its 16-bit register part and its extension bits, and a disk address moved forward to the next whole-sector boundary. The drive field does not change.

All the arithmetic is combinational. A one-cycle done strobe latches the results into output registers, and a valid pulse marks the new values. Moving the data itself happens outside this block. Because a partial last sector counts as a whole one, a write that zero-pads its tail and a read that stops early both leave the disk address on the next free sector.

Top module: `xfer_reg_update`

## Requirements
- R1: While reset is active and until the first strobe, `valid_o`, `wc_o`, `ba_o`, `ext_o` and `da_o` are all zero.
- R2: `valid_o` is high for exactly the one cycle after a cycle in which `done_i` is high. While `done_i` stays low, every result output keeps its value.
- R3: The effective moved count is `xfer_words_i - short_words_i`. When `short_words_i` is greater than or equal to `xfer_words_i`, the effective count is 0.
- R4: `wc_o` equals `wc_i` plus the effective moved count, modulo 65536.
- R5: The start byte address is `ext_i` at bits 17:16 above `ba_i`. The final byte address is the start plus twice the effective count, modulo 2^18. `ba_o` is bits 15:0 of the final address and `ext_o` is bits 17:16.
- R6: Bit 0 of `ba_i` is ignored: `ba_o[0]` is always 0, and setting `ba_i[0]` changes no output.
- R7: `da_i` holds the sector in bits 3:0 and the track in bits 12:4. The start sector index is track*12+sector. The new index is the start index plus the effective count divided by 256 and rounded up. `da_o` carries the new index divided by 12 (modulo 512) as its track and the remainder as its sector, which is always below 12.
- R8: `da_o[15:13]` (drive) equals `da_i[15:13]` from the strobe cycle.
- R9: With an effective count of 0, the disk position is unchanged apart from renormalisation: a sector field of 12..15 carries into the track.
- R10: A partial sector counts as a whole one. Counts of 1 and 256 both advance one sector, and a count of 257 advances two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | Transfer-finished strobe, latches results |
| wc_i | input | 16 | Starting word-count register (negated count) |
| ba_i | input | 16 | Starting bus address register |
| ext_i | input | 2 | Starting memory extension bits |
| da_i | input | 16 | Starting disk address {drive, track, sector} |
| xfer_words_i | input | 17 | Words requested for the transfer (0..65536) |
| short_words_i | input | 17 | Words left unmoved by a memory fault |
| valid_o | output | 1 | One-cycle pulse: new results present |
| wc_o | output | 16 | Final word-count register |
| ba_o | output | 16 | Final bus address register, bit 0 zero |
| ext_o | output | 2 | Final memory extension bits |
| da_o | output | 16 | Final disk address {drive, track, sector} |

## Verification
The block keeps no state beyond its output registers, so any fault shows on the ports in the cycle after the strobe. A fault in the moved-count subtraction shifts all three results together. A dropped carry from the 16-bit address into the extension shows only when the address crosses a 64 KiB boundary. A wrong round-up or split by twelve shows only at sector and track boundaries. The sweeps therefore aim at those edges: bus addresses near 0xFFFE under every extension value, counts at 0, 1, 255, 256, 257 and the maximum, and all sixteen sector codes on tracks that include the last one. A register that updates without a strobe shows in the hold check one cycle later.

// File: rtl/xfer_upd_pkg.sv
package xfer_upd_pkg;
  localparam int unsigned DEF_WC_W         = 16;
  localparam int unsigned DEF_BA_W         = 16;
  localparam int unsigned DEF_EXT_W        = 2;
  localparam int unsigned DEF_DRV_W        = 3;
  localparam int unsigned DEF_TRK_W        = 9;
  localparam int unsigned DEF_SEC_W        = 4;
  localparam int unsigned DEF_SECT_PER_TRK = 12;
  localparam int unsigned DEF_WORDS_SECT   = 256;
  localparam int unsigned DEF_CNT_W        = 17;
endpackage

// File: rtl/xfer_moved_calc.sv
module xfer_moved_calc #(
  parameter int unsigned CNT_W = 17
) (
  input  logic [CNT_W-1:0] xfer_i,
  input  logic [CNT_W-1:0] short_i,
  output logic [CNT_W-1:0] moved_o
);
  function automatic logic [CNT_W-1:0] effective(input logic [CNT_W-1:0] req,
                                                 input logic [CNT_W-1:0] lost);
    if (lost >= req) return '0;
    return req - lost;
  endfunction

  assign moved_o = effective(xfer_i, short_i);
endmodule

// File: rtl/xfer_count_calc.sv
module xfer_count_calc #(
  parameter int unsigned WC_W  = 16,
  parameter int unsigned CNT_W = 17
) (
  input  logic [WC_W-1:0]  wc_i,
  input  logic [CNT_W-1:0] moved_i,
  output logic [WC_W-1:0]  wc_o
);
  function automatic logic [WC_W-1:0] final_count(input logic [WC_W-1:0] start,
                                                  input logic [CNT_W-1:0] n);
    return start + WC_W'(n);
  endfunction

  assign wc_o = final_count(wc_i, moved_i);
endmodule

// File: rtl/xfer_addr_calc.sv
module xfer_addr_calc #(
  parameter int unsigned BA_W  = 16,
  parameter int unsigned EXT_W = 2,
  parameter int unsigned CNT_W = 17
) (
  input  logic [BA_W-1:0]  ba_i,
  input  logic [EXT_W-1:0] ext_i,
  input  logic [CNT_W-1:0] moved_i,
  output logic [BA_W-1:0]  ba_o,
  output logic [EXT_W-1:0] ext_o
);
  localparam int unsigned FULL_W = BA_W + EXT_W;
  localparam logic [BA_W-1:0] BA_MASK = ~BA_W'(1);

  function automatic logic [FULL_W-1:0] final_byte_addr(input logic [EXT_W-1:0] ext,
                                                        input logic [BA_W-1:0] ba,
                                                        input logic [CNT_W-1:0] n);
    logic [FULL_W-1:0] start;
    start = {ext, ba & BA_MASK};
    return start + (FULL_W'(n) << 1);
  endfunction

  logic [FULL_W-1:0] full_addr;
  assign full_addr = final_byte_addr(ext_i, ba_i, moved_i);
  assign ba_o  = full_addr[BA_W-1:0];
  assign ext_o = full_addr[FULL_W-1:BA_W];
endmodule

// File: rtl/xfer_disk_calc.sv
module xfer_disk_calc #(
  parameter int unsigned TRK_W        = 9,
  parameter int unsigned SEC_W        = 4,
  parameter int unsigned SECT_PER_TRK = 12,
  parameter int unsigned WORDS_SECT   = 256,
  parameter int unsigned CNT_W        = 17
) (
  input  logic [TRK_W-1:0] trk_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [CNT_W-1:0] moved_i,
  output logic [TRK_W-1:0] trk_o,
  output logic [SEC_W-1:0] sec_o
);
  localparam int unsigned WSH   = $clog2(WORDS_SECT);
  localparam int unsigned LIN_W = TRK_W + $clog2(SECT_PER_TRK) + 1;
  localparam int unsigned BIG_W = (LIN_W + WSH > CNT_W) ? LIN_W + WSH : CNT_W;
  localparam int unsigned POS_W = BIG_W + 2;
  localparam logic [POS_W-1:0] SPT_V  = POS_W'(SECT_PER_TRK);
  localparam logic [POS_W-1:0] ROUND  = POS_W'(WORDS_SECT - 1);

  function automatic logic [POS_W-1:0] next_index(input logic [TRK_W-1:0] trk,
                                                  input logic [SEC_W-1:0] sec,
                                                  input logic [CNT_W-1:0] n);
    logic [POS_W-1:0] start_idx;
    logic [POS_W-1:0] word_pos;
    start_idx = POS_W'(trk) * SPT_V + POS_W'(sec);
    word_pos  = (start_idx << WSH) + POS_W'(n) + ROUND;
    return word_pos >> WSH;
  endfunction

  logic [POS_W-1:0] new_idx;
  assign new_idx = next_index(trk_i, sec_i, moved_i);
  assign trk_o   = TRK_W'(new_idx / SPT_V);
  assign sec_o   = SEC_W'(new_idx % SPT_V);
endmodule

// File: rtl/xfer_reg_update.sv
module xfer_reg_update
  import xfer_upd_pkg::*;
#(
  parameter int unsigned WC_W         = DEF_WC_W,
  parameter int unsigned BA_W         = DEF_BA_W,
  parameter int unsigned EXT_W        = DEF_EXT_W,
  parameter int unsigned DRV_W        = DEF_DRV_W,
  parameter int unsigned TRK_W        = DEF_TRK_W,
  parameter int unsigned SEC_W        = DEF_SEC_W,
  parameter int unsigned SECT_PER_TRK = DEF_SECT_PER_TRK,
  parameter int unsigned WORDS_SECT   = DEF_WORDS_SECT,
  parameter int unsigned CNT_W        = DEF_CNT_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           done_i,
  input  logic [WC_W-1:0]                wc_i,
  input  logic [BA_W-1:0]                ba_i,
  input  logic [EXT_W-1:0]               ext_i,
  input  logic [DRV_W+TRK_W+SEC_W-1:0]   da_i,
  input  logic [CNT_W-1:0]               xfer_words_i,
  input  logic [CNT_W-1:0]               short_words_i,
  output logic                           valid_o,
  output logic [WC_W-1:0]                wc_o,
  output logic [BA_W-1:0]                ba_o,
  output logic [EXT_W-1:0]               ext_o,
  output logic [DRV_W+TRK_W+SEC_W-1:0]   da_o
);
  localparam int unsigned DA_W = DRV_W + TRK_W + SEC_W;

  logic [DRV_W-1:0] drv_in;
  logic [TRK_W-1:0] trk_in, trk_next;
  logic [SEC_W-1:0] sec_in, sec_next;
  logic [CNT_W-1:0] moved_w;
  logic [WC_W-1:0]  wc_next;
  logic [BA_W-1:0]  ba_next;
  logic [EXT_W-1:0] ext_next;
  logic [DA_W-1:0]  da_next;

  assign {drv_in, trk_in, sec_in} = da_i;

  xfer_moved_calc #(.CNT_W(CNT_W)) u_moved (
    .xfer_i(xfer_words_i), .short_i(short_words_i), .moved_o(moved_w));

  xfer_count_calc #(.WC_W(WC_W), .CNT_W(CNT_W)) u_count (
    .wc_i(wc_i), .moved_i(moved_w), .wc_o(wc_next));

  xfer_addr_calc #(.BA_W(BA_W), .EXT_W(EXT_W), .CNT_W(CNT_W)) u_addr (
    .ba_i(ba_i), .ext_i(ext_i), .moved_i(moved_w),
    .ba_o(ba_next), .ext_o(ext_next));

  xfer_disk_calc #(.TRK_W(TRK_W), .SEC_W(SEC_W), .SECT_PER_TRK(SECT_PER_TRK),
                   .WORDS_SECT(WORDS_SECT), .CNT_W(CNT_W)) u_disk (
    .trk_i(trk_in), .sec_i(sec_in), .moved_i(moved_w),
    .trk_o(trk_next), .sec_o(sec_next));

  assign da_next = {drv_in, trk_next, sec_next};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      wc_o    <= '0;
      ba_o    <= '0;
      ext_o   <= '0;
      da_o    <= '0;
    end else begin
      valid_o <= done_i;
      if (done_i) begin
        wc_o  <= wc_next;
        ba_o  <= ba_next;
        ext_o <= ext_next;
        da_o  <= da_next;
      end
    end
  end
endmodule

// File: rtl/xfer_reg_update_chk.sv
module xfer_reg_update_chk #(
  parameter int unsigned WC_W         = 16,
  parameter int unsigned BA_W         = 16,
  parameter int unsigned EXT_W        = 2,
  parameter int unsigned DRV_W        = 3,
  parameter int unsigned TRK_W        = 9,
  parameter int unsigned SEC_W        = 4,
  parameter int unsigned SECT_PER_TRK = 12,
  parameter int unsigned CNT_W        = 17
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         done_i,
  input logic [WC_W-1:0]              wc_i,
  input logic [DRV_W+TRK_W+SEC_W-1:0] da_i,
  input logic [CNT_W-1:0]             xfer_words_i,
  input logic [CNT_W-1:0]             short_words_i,
  input logic                         valid_o,
  input logic [WC_W-1:0]              wc_o,
  input logic [BA_W-1:0]              ba_o,
  input logic [EXT_W-1:0]             ext_o,
  input logic [DRV_W+TRK_W+SEC_W-1:0] da_o
);
  localparam int unsigned DA_W = DRV_W + TRK_W + SEC_W;

  AST_VALID_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> valid_o); // R2
  AST_VALID_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> !valid_o); // R2
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> ($stable(wc_o) && $stable(ba_o) && $stable(ext_o) && $stable(da_o))); // R2
  AST_ZERO_MOVE_WC: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && short_words_i >= xfer_words_i) |=> (wc_o == $past(wc_i))); // R3
  AST_BA_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ba_o[0] == 1'b0); // R6
  AST_SECT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (32'(da_o[SEC_W-1:0]) < SECT_PER_TRK)); // R7
  AST_DRIVE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (da_o[DA_W-1:DA_W-DRV_W] == $past(da_i[DA_W-1:DA_W-DRV_W]))); // R8
endmodule

bind xfer_reg_update xfer_reg_update_chk #(
  .WC_W(WC_W), .BA_W(BA_W), .EXT_W(EXT_W), .DRV_W(DRV_W), .TRK_W(TRK_W),
  .SEC_W(SEC_W), .SECT_PER_TRK(SECT_PER_TRK), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .done_i(done_i), .wc_i(wc_i), .da_i(da_i),
  .xfer_words_i(xfer_words_i), .short_words_i(short_words_i),
  .valid_o(valid_o), .wc_o(wc_o), .ba_o(ba_o), .ext_o(ext_o), .da_o(da_o)
);

// File: tb/xfer_reg_update_tb.sv
`timescale 1ns/1ps
module xfer_reg_update_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        done_i = 1'b0;
  logic [15:0] wc_i = '0;
  logic [15:0] ba_i = '0;
  logic [1:0]  ext_i = '0;
  logic [15:0] da_i = '0;
  logic [16:0] xfer_words_i = '0;
  logic [16:0] short_words_i = '0;
  logic        valid_o;
  logic [15:0] wc_o;
  logic [15:0] ba_o;
  logic [1:0]  ext_o;
  logic [15:0] da_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  xfer_reg_update u_dut (
    .clk(clk), .rst_n(rst_n), .done_i(done_i), .wc_i(wc_i), .ba_i(ba_i),
    .ext_i(ext_i), .da_i(da_i), .xfer_words_i(xfer_words_i),
    .short_words_i(short_words_i), .valid_o(valid_o), .wc_o(wc_o),
    .ba_o(ba_o), .ext_o(ext_o), .da_o(da_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Apply one transfer and check all results; expected values from the requirements.
  task automatic run_xfer(input int wc, input int ba, input int ext, input int drv,
                          input int trk, input int sec, input int xfer, input int shrt);
    int moved, exp_wc, byte_a, exp_ba, exp_ext, adv, idx, exp_trk, exp_sec;
    logic [15:0] hold_wc, hold_ba, hold_da;
    moved   = (shrt >= xfer) ? 0 : xfer - shrt;             // R3
    exp_wc  = (wc + moved) % 65536;                          // R4
    byte_a  = (ext * 65536 + (ba / 2) * 2 + 2 * moved) % 262144; // R5 R6
    exp_ba  = byte_a % 65536;
    exp_ext = byte_a / 65536;
    adv     = moved / 256 + ((moved % 256) != 0 ? 1 : 0);    // R10
    idx     = trk * 12 + sec + adv;                          // R7 R9
    exp_trk = (idx / 12) % 512;
    exp_sec = idx % 12;
    @(negedge clk);
    wc_i = wc[15:0]; ba_i = ba[15:0]; ext_i = ext[1:0];
    da_i = {drv[2:0], trk[8:0], sec[3:0]};
    xfer_words_i = xfer[16:0]; short_words_i = shrt[16:0];
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
    check(valid_o == 1'b1, "R2 valid", int'(valid_o), 1);
    check(int'(wc_o) == exp_wc, "R4 wc", int'(wc_o), exp_wc);
    check(int'(ba_o) == exp_ba, "R5 ba", int'(ba_o), exp_ba);
    check(int'(ext_o) == exp_ext, "R5 ext", int'(ext_o), exp_ext);
    check(int'(da_o[12:4]) == exp_trk, "R7 track", int'(da_o[12:4]), exp_trk);
    check(int'(da_o[3:0]) == exp_sec, "R7 sector", int'(da_o[3:0]), exp_sec);
    check(int'(da_o[15:13]) == drv, "R8 drive", int'(da_o[15:13]), drv);
    hold_wc = wc_o; hold_ba = ba_o; hold_da = da_o;
    wc_i = ~wc_i; ba_i = ~ba_i; da_i = ~da_i;
    @(negedge clk);
    check(valid_o == 1'b0, "R2 one-shot", int'(valid_o), 0);
    check(wc_o == hold_wc && ba_o == hold_ba && da_o == hold_da, "R2 hold",
          int'(da_o), int'(hold_da));
  endtask

  int ba_set[4]  = '{0, 1, 32'hFFFE, 32'h8001};
  int cnt_set[8] = '{0, 1, 255, 256, 257, 32767, 65535, 65536};
  int trk_set[4] = '{0, 1, 100, 511};

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(valid_o == 1'b0, "R1 valid", int'(valid_o), 0);
    check(wc_o == 0 && ba_o == 0 && ext_o == 0 && da_o == 0, "R1 outputs",
          int'(da_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid_o == 1'b0 && da_o == 0, "R1 after release", int'(da_o), 0);

    // R5 R6: address carry into extension bits, bit 0 ignored
    for (int e = 0; e < 4; e++)
      for (int b = 0; b < 4; b++)
        for (int m = 0; m < 8; m++)
          run_xfer(32'h10000 - cnt_set[m] % 65536, ba_set[b], e, e + 1, 5, 3, cnt_set[m], 0);

    // R7 R9 R10: sector round-up and split over every sector code
    for (int t = 0; t < 4; t++)
      for (int s = 0; s < 16; s++)
        for (int m = 0; m < 8; m++)
          run_xfer(32'hFF00, 32'h1000, 0, (t + s) % 8, trk_set[t], s, cnt_set[m], 0);

    // R3: memory fault shortens the moved count, saturating at zero
    run_xfer(32'hFED4, 32'h2000, 1, 2, 7, 11, 300, 44);
    run_xfer(32'hFED4, 32'hFFFE, 3, 6, 511, 11, 300, 299);
    run_xfer(32'h0100, 32'h4000, 2, 5, 10, 13, 20, 21);
    run_xfer(32'h0000, 32'h0002, 0, 7, 0, 15, 65536, 65536);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule